// File: doc/BRIEF.md
# Flow-Controlled Asynchronous Serial Transmitter

This block turns 7-bit characters written by a processor into asynchronous serial frames on a single output line. A write places a character in a one-entry holding register. When the line is free, the frame engine copies the character into its shift register, which frees the holding register at once. Software can therefore queue the next character while the current one is still on the wire. Each bit on the line lasts a fixed number of ticks of an externally supplied baud tick.

New frames start only when the far end permits them. A clear-to-send input gives hardware flow control, and a pause input (driven by a local receiver that has seen a software stop request) gives software flow control. Both are looked at only while no frame is running, so a frame that has started always runs to its end. A level-sensitive interrupt reports an empty holding register and can be masked. A sticky flag records any write that arrived while the holding register was still occupied.

The frame engine has five named states. IDLE holds the line high. START drives the low start bit. DATA sends the character bits, least significant first. PARITY sends the parity bit. STOP sends the high stop bit. The transitions are: IDLE to START when the holding register is full, clear-to-send is high and pause is low (launch); START to DATA after one bit time; DATA to DATA after each bit time until the seventh bit; DATA to PARITY after the seventh bit; PARITY to STOP after one bit time; and STOP to IDLE after one bit time (frame end).

Top module: `uart_tx_fc`

## Requirements
- R1: After reset `txd` is 1, `tbe` is 1, `wr_ovf` is 0, and `irq` equals `irq_en`.
- R2: A frame is a 0 start bit, then `wr_data[0]` through `wr_data[6]` in that order, then the parity bit, then a 1 stop bit. Between frames the line stays at 1.
- R3: The parity bit is the XOR of the seven data bits when `par_odd` is 0 (even parity) and its inverse when `par_odd` is 1 (odd parity). `par_odd` is sampled when the character moves into the shift register.
- R4: Every bit lasts 16 `baud_tick` pulses. When `baud_tick` is high on every clock, the start bit is exactly 16 clocks long.
- R5: A character written while a frame is being sent goes out in the next frame, in write order, with no character lost.
- R6: `tbe` goes to 0 on the clock edge that accepts a write. It returns to 1 on the edge where the character moves into the shift register, which is also the edge where the start bit begins.
- R7: `irq` is 1 exactly when `tbe` is 1 and `irq_en` is 1.
- R8: A write while the holding register is full and not being emptied on that edge is dropped: the held character is kept and is the one sent, and `wr_ovf` becomes 1 and stays 1 until reset.
- R9: While `cts` is 0, no new frame starts and `txd` stays at 1. Once `cts` returns to 1, the held character is sent.
- R10: While `pause` is 1, no new frame starts and `txd` stays at 1. Once `pause` returns to 0, the held character is sent.
- R11: A frame already started completes unchanged if `cts` falls or `pause` rises during it. A character queued behind it is held until flow control allows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe for the holding register |
| wr_data | input | 7 | Character to transmit |
| par_odd | input | 1 | Parity select: 0 even, 1 odd |
| irq_en | input | 1 | Interrupt enable (0 masks `irq`) |
| baud_tick | input | 1 | One-clock pulse at 16 times the bit rate |
| cts | input | 1 | Clear to send, 1 permits frame starts |
| pause | input | 1 | Software flow-control stop, 1 holds off frame starts |
| txd | output | 1 | Serial data out, idle high |
| tbe | output | 1 | Holding register empty |
| irq | output | 1 | Level interrupt: empty and enabled |
| wr_ovf | output | 1 | Sticky flag for a dropped write |

## Verification
Some properties are checked on every cycle: the overflow flag never clears outside reset, an accepted write always empties `tbe` on the next cycle, the engine never leaves IDLE and the line never drops while `cts` is low or `pause` is high, and `tbe` rises only on the edge that launches a frame. Other behaviour can only be shown by the bench's scenarios: the bit content and parity of every character in both parity modes, the bit length under slow and fast tick rates, the order of queued characters, a dropped character never appearing on the line, and a frame running to its end after flow control closes mid-frame.

// File: rtl/uart_tx_fc_pkg.sv
package uart_tx_fc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4
    } tx_state_t;
endpackage

// File: rtl/tx_hold_buf.sv
module tx_hold_buf #(
    parameter int DW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          take,
    output logic          full,
    output logic [DW-1:0] data,
    output logic          ovf
);
    logic accept;

    // A write on the same edge as a take refills the freed slot.
    assign accept = wr_en && (!full || take);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
            ovf  <= 1'b0;
        end else begin
            if (accept) begin
                data <= wr_data;
            end
            full <= accept || (full && !take);
            if (wr_en && !accept) begin
                ovf <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
    parameter int TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic baud_tick,
    output logic bit_done
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt;

    assign bit_done = baud_tick && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (baud_tick) begin
            cnt <= bit_done ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tx_parity_gen.sv
module tx_parity_gen #(
    parameter int DW = 7
) (
    input  logic [DW-1:0] data,
    input  logic          odd,
    output logic          par
);
    assign par = (^data) ^ odd;
endmodule

// File: rtl/uart_tx_fc.sv
module uart_tx_fc #(
    parameter int DATA_BITS     = 7,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [DATA_BITS-1:0] wr_data,
    input  logic                 par_odd,
    input  logic                 irq_en,
    input  logic                 baud_tick,
    input  logic                 cts,
    input  logic                 pause,
    output logic                 txd,
    output logic                 tbe,
    output logic                 irq,
    output logic                 wr_ovf
);
    import uart_tx_fc_pkg::*;

    localparam int IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [IW-1:0] LAST_BIT = IW'(DATA_BITS - 1);

    tx_state_t            state_q, state_d;
    logic [IW-1:0]        bit_idx_q;
    logic [DATA_BITS:0]   shreg_q;
    logic                 hold_full;
    logic [DATA_BITS-1:0] hold_data;
    logic                 launch;
    logic                 bit_done;
    logic                 par_bit;

    assign launch = (state_q == ST_IDLE) && hold_full && cts && !pause;

    tx_hold_buf #(.DW(DATA_BITS)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (launch),
        .full    (hold_full),
        .data    (hold_data),
        .ovf     (wr_ovf)
    );

    tx_bit_timer #(.TICKS(TICKS_PER_BIT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (state_q == ST_IDLE),
        .baud_tick (baud_tick),
        .bit_done  (bit_done)
    );

    tx_parity_gen #(.DW(DATA_BITS)) u_par (
        .data (hold_data),
        .odd  (par_odd),
        .par  (par_bit)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (launch)   state_d = ST_START;
            ST_START:  if (bit_done) state_d = ST_DATA;
            ST_DATA:   if (bit_done && bit_idx_q == LAST_BIT) state_d = ST_PARITY;
            ST_PARITY: if (bit_done) state_d = ST_STOP;
            ST_STOP:   if (bit_done) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register with the shift datapath it steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bit_idx_q <= '0;
            shreg_q   <= '1;
        end else begin
            state_q <= state_d;
            if (launch) begin
                shreg_q   <= {par_bit, hold_data};
                bit_idx_q <= '0;
            end else if (state_q == ST_DATA && bit_done) begin
                shreg_q   <= {1'b1, shreg_q[DATA_BITS:1]};
                bit_idx_q <= bit_idx_q + 1'b1;
            end
        end
    end

    // After the last data shift the parity bit sits in bit 0.
    always_comb begin
        unique case (state_q)
            ST_IDLE:   txd = 1'b1;
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = shreg_q[0];
            ST_PARITY: txd = shreg_q[0];
            ST_STOP:   txd = 1'b1;
            default:   txd = 1'b1;
        endcase
        tbe = !hold_full;
        irq = !hold_full && irq_en;
    end
endmodule

// File: rtl/uart_tx_fc_chk.sv
module uart_tx_fc_chk
    import uart_tx_fc_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      wr_en,
    input logic      cts,
    input logic      pause,
    input logic      txd,
    input logic      tbe,
    input logic      wr_ovf,
    input tx_state_t state
);
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ovf |=> wr_ovf);

    p_write_fills_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tbe) |=> !tbe);

    p_cts_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !cts) |=> (state == ST_IDLE && txd));

    p_pause_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && pause) |=> (state == ST_IDLE && txd));

    p_empty_on_launch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tbe) |-> ($past(state) == ST_IDLE && state == ST_START));

    p_data_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |=> (state == ST_DATA || state == ST_PARITY));

    p_frame_runs_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PARITY) |=> (state == ST_PARITY || state == ST_STOP));
endmodule

bind uart_tx_fc uart_tx_fc_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .cts    (cts),
    .pause  (pause),
    .txd    (txd),
    .tbe    (tbe),
    .wr_ovf (wr_ovf),
    .state  (state_q)
);

// File: tb/uart_tx_fc_tb.sv
`timescale 1ns/1ps
module uart_tx_fc_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [6:0] wr_data = '0;
    logic       par_odd = 1'b0;
    logic       irq_en = 1'b1;
    logic       baud_tick = 1'b0;
    logic       cts = 1'b1;
    logic       pause = 1'b0;
    logic       txd, tbe, irq, wr_ovf;

    int checks = 0;
    int failures = 0;
    int rx_count = 0;
    int div = 1;
    int tick_ph = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    uart_tx_fc u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .par_odd(par_odd), .irq_en(irq_en), .baud_tick(baud_tick),
        .cts(cts), .pause(pause), .txd(txd), .tbe(tbe), .irq(irq),
        .wr_ovf(wr_ovf)
    );

    // Baud tick: one pulse every div clocks, driven at the falling edge.
    always @(negedge clk) begin
        if (tick_ph >= div - 1) begin
            tick_ph   <= 0;
            baud_tick <= 1'b1;
        end else begin
            tick_ph   <= tick_ph + 1;
            baud_tick <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_char(input logic [6:0] c);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = c;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic send_queued(input logic [6:0] c);
        while (tbe !== 1'b1) @(negedge clk);
        exp_q.push_back({par_odd, c});
        write_char(c);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (20 * div) @(negedge clk);
    endtask

    // Line monitor: decodes each frame at bit centres and compares it.
    initial begin
        logic [6:0] d;
        logic       p, s0, sp;
        logic [7:0] e;
        int         dv;
        forever begin
            @(negedge clk);
            if (rst_n && txd === 1'b0) begin
                dv = div;
                repeat (8 * dv - 1) @(negedge clk);
                s0 = txd;
                for (int i = 0; i < 7; i++) begin
                    repeat (16 * dv) @(negedge clk);
                    d[i] = txd;
                end
                repeat (16 * dv) @(negedge clk);
                p = txd;
                repeat (16 * dv) @(negedge clk);
                sp = txd;
                rx_count++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected frame on line", int'(d), -1);
                end else begin
                    e = exp_q.pop_front();
                    check(s0 == 1'b0 && sp == 1'b1 && d == e[6:0],
                          "R2 frame content", int'({s0, d, sp}), int'({1'b0, e[6:0], 1'b1}));
                    check(p == ((^e[6:0]) ^ e[7]), "R3 parity bit",
                          int'(p), int'((^e[6:0]) ^ e[7]));
                end
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int run, base;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(txd == 1'b1, "R1 txd idle", txd, 1);
        check(tbe == 1'b1, "R1 tbe", tbe, 1);
        check(wr_ovf == 1'b0, "R1 wr_ovf", wr_ovf, 0);
        check(irq == 1'b1, "R1 irq", irq, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 mask
        irq_en = 1'b0;
        @(negedge clk);
        check(irq == 1'b0, "R7 masked irq", irq, 0);
        irq_en = 1'b1;
        @(negedge clk);
        check(irq == 1'b1, "R7 enabled irq", irq, 1);

        // R6 tbe timing and R4 start bit length (0x7F: only the start bit is low)
        exp_q.push_back({par_odd, 7'h7F});
        @(negedge clk);
        wr_en = 1'b1; wr_data = 7'h7F;
        @(negedge clk);
        wr_en = 1'b0;
        check(tbe == 1'b0, "R6 tbe clears on write", tbe, 0);
        check(irq == 1'b0, "R7 irq follows tbe", irq, 0);
        @(negedge clk);
        check(tbe == 1'b1, "R6 tbe sets on transfer", tbe, 1);
        check(txd == 1'b0, "R6 start bit begins at transfer", txd, 0);
        run = 0;
        while (txd == 1'b0) begin run++; @(negedge clk); end
        check(run == 16, "R4 start bit clocks", run, 16);
        drain();

        // R2 R3 R5 sweep: every character in both parity modes, back to back
        for (int m = 0; m < 2; m++) begin
            par_odd = m[0];
            for (int c = 0; c < 128; c++) send_queued(7'(c));
            drain();
        end
        check(rx_count == 257, "R5 all queued characters sent", rx_count, 257);

        // R9 cts holds off
        cts = 1'b0;
        base = rx_count;
        send_queued(7'h15);
        repeat (300) @(negedge clk);
        check(txd == 1'b1 && rx_count == base, "R9 held by cts", rx_count, base);
        check(tbe == 1'b0, "R9 character kept", tbe, 0);
        // R8 overflow while held
        write_char(7'h6A);
        check(wr_ovf == 1'b1, "R8 overflow flag", wr_ovf, 1);
        cts = 1'b1;
        drain();
        repeat (200) @(negedge clk);
        check(rx_count == base + 1, "R8 dropped write not sent", rx_count, base + 1);
        send_queued(7'h01);
        drain();
        check(wr_ovf == 1'b1, "R8 overflow sticky", wr_ovf, 1);

        // R10 pause holds off
        pause = 1'b1;
        base = rx_count;
        send_queued(7'h33);
        repeat (300) @(negedge clk);
        check(txd == 1'b1 && rx_count == base, "R10 held by pause", rx_count, base);
        pause = 1'b0;
        drain();
        check(rx_count == base + 1, "R10 sent after release", rx_count, base + 1);

        // R11 flow control closes mid-frame
        base = rx_count;
        send_queued(7'h55);
        while (txd != 1'b0) @(negedge clk);
        repeat (20) @(negedge clk);
        cts = 1'b0;
        send_queued(7'h2A);
        repeat (300) @(negedge clk);
        check(rx_count == base + 1, "R11 running frame completed", rx_count, base + 1);
        check(tbe == 1'b0 && txd == 1'b1, "R11 queued character held", tbe, 0);
        cts = 1'b1;
        drain();
        check(rx_count == base + 2, "R11 queued character sent", rx_count, base + 2);

        // R4 slow tick rate
        div = 3;
        repeat (10) @(negedge clk);
        par_odd = 1'b1;
        exp_q.push_back({par_odd, 7'h7F});
        write_char(7'h7F);
        while (txd != 1'b0) @(negedge clk);
        run = 0;
        while (txd == 1'b0) begin run++; @(negedge clk); end
        check(run >= 46 && run <= 48, "R4 start bit at divided tick", run, 48);
        drain();
        send_queued(7'h4B);
        send_queued(7'h12);
        drain();
        check(exp_q.size() == 0, "R5 queue empty at end", exp_q.size(), 0);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule